// File: doc/BRIEF.md
# Instruction Field Decoder and Control

This block takes a 32-bit instruction word and, in the same cycle, splits it into its opcode, three register fields and a 16-bit literal, and produces every control signal a single-cycle datapath needs: the ALU operation, whether operand B comes from a register or from the sign-extended literal, the register write enable and its source, the memory read and write strobes, the branch or jump kind, and an illegal-instruction trap request. The register file, ALU, memory and the trap sequencer that vectors to address 4 sit outside.

Two encodings exist. Opcodes with the top bit set are ALU operations; bit 4 selects the register-operand form (0x20–0x2F) or the literal form (0x30–0x3F), and the low four bits name the ALU function. Below 0x20 only load, store, jump, the two conditional branches, the privileged operation and the service call are defined. A store reads its data from the register named in the destination field, so the decoder steers that field onto the second read port. The privileged opcode and the service call both carry a function code in the literal field, which is brought out so the surrounding machine can act on it.

A supervisor-mode input gates the privileged opcode. Division is optional and chosen by a parameter; when left out, the division opcodes trap like any other undefined code.

Top module: `instr_decoder`

## Requirements
- R1: Fields sit at fixed positions: opcode bits 31:26, destination bits 25:21, source A bits 20:16, source B bits 15:11, literal bits 15:0; `lit_o` is the literal sign-extended to 32 bits.
- R2: A defined register-format opcode (0x20–0x2F) sets `alu_op_o` to opcode bits 3:0, `bsel_lit_o`=0, `rd_b_o` to the source B field, `reg_we_o`=1 and `wb_sel_o`=0 (ALU); ALU codes: 0 add, 1 sub, 2 mul, 3 div, 4 eq, 5 lt, 6 le, 8 and, 9 or, 10 xor, 11 xnor, 12 shl, 13 shr, 14 sra.
- R3: A defined literal-format opcode (0x30–0x3F) decodes as its register-format twin but with `bsel_lit_o`=1.
- R4: Opcode 0x18 (load) gives `mem_rd_o`=1, `wb_sel_o`=1 (memory), `reg_we_o`=1, `bsel_lit_o`=1, `alu_op_o`=0 (address add).
- R5: Opcode 0x19 (store) gives `mem_wr_o`=1, `reg_we_o`=0, `bsel_lit_o`=1, `alu_op_o`=0 and `rd_b_o` equal to the destination field.
- R6: Opcode 0x1B gives `br_kind_o`=3 (jump to register A, `bsel_lit_o`=0); 0x1C gives 1 (taken when A is zero) and 0x1D gives 2 (taken when A is non-zero), both with `bsel_lit_o`=1; all three write the return address (`wb_sel_o`=2) to the destination.
- R7: When the destination field is 31, `reg_we_o` is 0 for every opcode.
- R8: Any opcode not defined here (0x02–0x17, 0x1A, 0x1E, 0x1F, 0x27, 0x2F, 0x37, 0x3F) sets `ill_trap_o`=1 and forces `reg_we_o`, `mem_rd_o`, `mem_wr_o`, `br_kind_o`, `alu_op_o`, `bsel_lit_o` and `wb_sel_o` to 0.
- R9: With `DIV_EN`=0 (default), opcodes 0x23 and 0x33 behave as in R8.
- R10: Opcode 0x00 with `super_i`=1 and a function code of 8 or less sets `priv_o`=1, `ill_trap_o`=0, no write or memory access, and `func_o` equal to literal bits 15:0.
- R11: Opcode 0x00 with `super_i`=0, or with a function code above 8, behaves as in R8 and leaves `priv_o`=0.
- R12: Opcode 0x01 sets `svc_o`=1 and `ill_trap_o`=1 in either mode, with `func_o` equal to the literal; `func_o` is 0 whenever neither `priv_o` nor `svc_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| super_i | input | 1 | Supervisor mode |
| opcode_o | output | 6 | Opcode field |
| rc_o | output | 5 | Destination field |
| ra_o | output | 5 | Source A field (read port A address) |
| rb_o | output | 5 | Source B field |
| rd_b_o | output | 5 | Read port B address (source B, or destination for store) |
| lit_o | output | 32 | Sign-extended literal |
| alu_op_o | output | 4 | ALU function |
| bsel_lit_o | output | 1 | Operand B is the literal |
| reg_we_o | output | 1 | Register write enable |
| wb_sel_o | output | 2 | Writeback source: 0 ALU, 1 memory, 2 return address |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| br_kind_o | output | 2 | 0 none, 1 branch if zero, 2 branch if non-zero, 3 jump |
| ill_trap_o | output | 1 | Illegal-instruction trap request |
| priv_o | output | 1 | Privileged operation accepted |
| svc_o | output | 1 | Service call |
| func_o | output | 16 | Function code of privileged op or service call |

## Verification
The trap request and the register write fall on the same instruction: an undefined, division or user-mode privileged opcode still carries a destination field, and the write must be dropped while the trap is raised. Likewise a branch or jump with destination 31 must steer control while its link write is discarded. Vectors pair each trapping opcode with a live destination and each control transfer with destination 31, and judge the whole control word, not just the trap bit.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int REG_W   = 5;
  localparam int LIT_W   = 16;
  localparam int DATA_W  = 32;

  localparam logic [OP_W-1:0] OP_PRIV = 6'h00;
  localparam logic [OP_W-1:0] OP_SVC  = 6'h01;
  localparam logic [OP_W-1:0] OP_LD   = 6'h18;
  localparam logic [OP_W-1:0] OP_ST   = 6'h19;
  localparam logic [OP_W-1:0] OP_JMP  = 6'h1B;
  localparam logic [OP_W-1:0] OP_BEQ  = 6'h1C;
  localparam logic [OP_W-1:0] OP_BNE  = 6'h1D;

  typedef enum logic [3:0] {
    ALU_ADD = 4'h0, ALU_SUB = 4'h1, ALU_MUL = 4'h2, ALU_DIV = 4'h3,
    ALU_CEQ = 4'h4, ALU_CLT = 4'h5, ALU_CLE = 4'h6,
    ALU_AND = 4'h8, ALU_OR  = 4'h9, ALU_XOR = 4'hA, ALU_XNR = 4'hB,
    ALU_SHL = 4'hC, ALU_SHR = 4'hD, ALU_SRA = 4'hE
  } alu_op_e;

  typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_PC4 = 2'd2} wb_sel_e;
  typedef enum logic [1:0] {BR_NONE = 2'd0, BR_EQZ = 2'd1, BR_NEZ = 2'd2, BR_JMP = 2'd3} br_kind_e;

  typedef enum logic [3:0] {
    K_ILL, K_ALU, K_LD, K_ST, K_JMP, K_BEQ, K_BNE, K_PRIV, K_SVC
  } op_kind_e;

  typedef struct packed {
    alu_op_e  alu;
    logic     bsel_lit;
    logic     wr_en;
    wb_sel_e  wb;
    logic     mrd;
    logic     mwr;
    br_kind_e br;
    logic     data_from_rc;
    logic     trap;
    logic     priv;
    logic     svc;
  } ctl_t;
endpackage

// File: rtl/dec_fields.sv
module dec_fields
  import instr_dec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output logic [OP_W-1:0]    opcode_o,
  output logic [REG_W-1:0]   rc_o,
  output logic [REG_W-1:0]   ra_o,
  output logic [REG_W-1:0]   rb_o,
  output logic [LIT_W-1:0]   lit_raw_o,
  output logic [DATA_W-1:0]  lit_sx_o
);
  localparam int OP_LSB = INSTR_W - OP_W;
  localparam int RC_LSB = OP_LSB - REG_W;
  localparam int RA_LSB = RC_LSB - REG_W;
  localparam int RB_LSB = RA_LSB - REG_W;
  localparam int EXT_W  = DATA_W - LIT_W;

  assign opcode_o  = instr_i[INSTR_W-1:OP_LSB];
  assign rc_o      = instr_i[OP_LSB-1:RC_LSB];
  assign ra_o      = instr_i[RC_LSB-1:RA_LSB];
  assign rb_o      = instr_i[RA_LSB-1:RB_LSB];
  assign lit_raw_o = instr_i[LIT_W-1:0];
  assign lit_sx_o  = {{EXT_W{instr_i[LIT_W-1]}}, instr_i[LIT_W-1:0]};
endmodule

// File: rtl/dec_class.sv
module dec_class
  import instr_dec_pkg::*;
#(
  parameter bit DIV_EN      = 1'b0,
  parameter int PRIV_FN_MAX = 8
) (
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [LIT_W-1:0] func_i,
  input  logic             super_i,
  output op_kind_e         kind_o
);
  localparam logic [3:0] FN_GAP0 = 4'h7;
  localparam logic [3:0] FN_GAP1 = 4'hF;
  localparam logic [3:0] FN_DIV  = 4'h3;

  logic div_ok;
  logic alu_fn_ok;

  generate
    if (DIV_EN) begin : g_div
      assign div_ok = 1'b1;
    end else begin : g_nodiv
      assign div_ok = 1'b0;
    end
  endgenerate

  assign alu_fn_ok = (opcode_i[3:0] != FN_GAP0) && (opcode_i[3:0] != FN_GAP1) &&
                     ((opcode_i[3:0] != FN_DIV) || div_ok);

  always_comb begin
    kind_o = K_ILL;
    unique case (opcode_i)
      OP_PRIV: kind_o = (super_i && (func_i <= LIT_W'(PRIV_FN_MAX))) ? K_PRIV : K_ILL;
      OP_SVC:  kind_o = K_SVC;
      OP_LD:   kind_o = K_LD;
      OP_ST:   kind_o = K_ST;
      OP_JMP:  kind_o = K_JMP;
      OP_BEQ:  kind_o = K_BEQ;
      OP_BNE:  kind_o = K_BNE;
      default: kind_o = (opcode_i[OP_W-1] && alu_fn_ok) ? K_ALU : K_ILL;
    endcase
  end
endmodule

// File: rtl/dec_ctrl.sv
module dec_ctrl
  import instr_dec_pkg::*;
(
  input  op_kind_e         kind_i,
  input  logic [3:0]       alu_fn_i,
  input  logic             lit_fmt_i,
  input  logic [REG_W-1:0] rc_i,
  output ctl_t             ctl_o
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;

  ctl_t raw;

  always_comb begin
    raw = '0;
    unique case (kind_i)
      K_ALU: begin
        raw.alu      = alu_op_e'(alu_fn_i);
        raw.bsel_lit = lit_fmt_i;
        raw.wr_en    = 1'b1;
        raw.wb       = WB_ALU;
      end
      K_LD: begin
        raw.alu      = ALU_ADD;
        raw.bsel_lit = 1'b1;
        raw.wr_en    = 1'b1;
        raw.wb       = WB_MEM;
        raw.mrd      = 1'b1;
      end
      K_ST: begin
        raw.alu          = ALU_ADD;
        raw.bsel_lit     = 1'b1;
        raw.mwr          = 1'b1;
        raw.data_from_rc = 1'b1;
      end
      K_JMP: begin
        raw.wr_en = 1'b1;
        raw.wb    = WB_PC4;
        raw.br    = BR_JMP;
      end
      K_BEQ, K_BNE: begin
        raw.bsel_lit = 1'b1;
        raw.wr_en    = 1'b1;
        raw.wb       = WB_PC4;
        raw.br       = (kind_i == K_BEQ) ? BR_EQZ : BR_NEZ;
      end
      K_PRIV: raw.priv = 1'b1;
      K_SVC: begin
        raw.svc  = 1'b1;
        raw.trap = 1'b1;
      end
      default: raw.trap = 1'b1;
    endcase
  end

  // register 31 is the zero sink: drop its writes here
  always_comb begin
    ctl_o       = raw;
    ctl_o.wr_en = raw.wr_en && (rc_i != ZERO_REG);
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
#(
  parameter bit DIV_EN      = 1'b0,
  parameter int PRIV_FN_MAX = 8
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               super_i,
  output logic [OP_W-1:0]    opcode_o,
  output logic [REG_W-1:0]   rc_o,
  output logic [REG_W-1:0]   ra_o,
  output logic [REG_W-1:0]   rb_o,
  output logic [REG_W-1:0]   rd_b_o,
  output logic [DATA_W-1:0]  lit_o,
  output logic [3:0]         alu_op_o,
  output logic               bsel_lit_o,
  output logic               reg_we_o,
  output logic [1:0]         wb_sel_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [1:0]         br_kind_o,
  output logic               ill_trap_o,
  output logic               priv_o,
  output logic               svc_o,
  output logic [LIT_W-1:0]   func_o
);
  logic [LIT_W-1:0] lit_raw;
  op_kind_e         kind;
  ctl_t             ctl;

  dec_fields u_fields (
    .instr_i   (instr_i),
    .opcode_o  (opcode_o),
    .rc_o      (rc_o),
    .ra_o      (ra_o),
    .rb_o      (rb_o),
    .lit_raw_o (lit_raw),
    .lit_sx_o  (lit_o)
  );

  dec_class #(
    .DIV_EN      (DIV_EN),
    .PRIV_FN_MAX (PRIV_FN_MAX)
  ) u_class (
    .opcode_i (opcode_o),
    .func_i   (lit_raw),
    .super_i  (super_i),
    .kind_o   (kind)
  );

  dec_ctrl u_ctrl (
    .kind_i    (kind),
    .alu_fn_i  (opcode_o[3:0]),
    .lit_fmt_i (opcode_o[4]),
    .rc_i      (rc_o),
    .ctl_o     (ctl)
  );

  assign rd_b_o     = ctl.data_from_rc ? rc_o : rb_o;
  assign alu_op_o   = ctl.alu;
  assign bsel_lit_o = ctl.bsel_lit;
  assign reg_we_o   = ctl.wr_en;
  assign wb_sel_o   = ctl.wb;
  assign mem_rd_o   = ctl.mrd;
  assign mem_wr_o   = ctl.mwr;
  assign br_kind_o  = ctl.br;
  assign ill_trap_o = ctl.trap;
  assign priv_o     = ctl.priv;
  assign svc_o      = ctl.svc;
  assign func_o     = (ctl.priv || ctl.svc) ? lit_raw : '0;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk (
  input logic [31:0] instr_i,
  input logic        super_i,
  input logic [5:0]  opcode_o,
  input logic [4:0]  rc_o,
  input logic [4:0]  rd_b_o,
  input logic [31:0] lit_o,
  input logic        reg_we_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic [1:0]  br_kind_o,
  input logic        ill_trap_o,
  input logic        priv_o,
  input logic        svc_o,
  input logic [15:0] func_o
);
  always_comb begin
    // R1
    sign_ext_chk: assert (lit_o[31:16] == {16{instr_i[15]}} && lit_o[15:0] == instr_i[15:0]);
    // R7
    zero_sink_chk: assert (!(rc_o == 5'd31 && reg_we_o));
    // R8
    trap_quiet_chk: assert (!ill_trap_o || (!reg_we_o && !mem_rd_o && !mem_wr_o && br_kind_o == 2'd0));
    // R5
    store_src_chk: assert (!mem_wr_o || (!reg_we_o && !mem_rd_o && rd_b_o == rc_o));
    // R10
    priv_mode_chk: assert (!priv_o || (super_i && !ill_trap_o && opcode_o == 6'h00));
    // R12
    svc_trap_chk: assert (!svc_o || ill_trap_o);
    // R12
    func_zero_chk: assert (priv_o || svc_o || func_o == 16'h0);
  end
endmodule

bind instr_decoder instr_decoder_chk u_chk (
  .instr_i    (instr_i),
  .super_i    (super_i),
  .opcode_o   (opcode_o),
  .rc_o       (rc_o),
  .rd_b_o     (rd_b_o),
  .lit_o      (lit_o),
  .reg_we_o   (reg_we_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .br_kind_o  (br_kind_o),
  .ill_trap_o (ill_trap_o),
  .priv_o     (priv_o),
  .svc_o      (svc_o),
  .func_o     (func_o)
);

// File: tb/tb_instr_decoder.sv
module tb_instr_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] instr;
  logic        sup;
  logic [5:0]  opcode;
  logic [4:0]  rc, ra, rb, rd_b;
  logic [31:0] lit;
  logic [3:0]  alu_op;
  logic        bsel, we, mrd, mwr, trap, priv, svc;
  logic [1:0]  wb, br;
  logic [15:0] func;

  instr_decoder dut (
    .instr_i(instr), .super_i(sup), .opcode_o(opcode), .rc_o(rc), .ra_o(ra),
    .rb_o(rb), .rd_b_o(rd_b), .lit_o(lit), .alu_op_o(alu_op), .bsel_lit_o(bsel),
    .reg_we_o(we), .wb_sel_o(wb), .mem_rd_o(mrd), .mem_wr_o(mwr), .br_kind_o(br),
    .ill_trap_o(trap), .priv_o(priv), .svc_o(svc), .func_o(func)
  );

  int total = 0;
  int bad = 0;

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] c, logic [4:0] a, logic [15:0] low);
    return {op, c, a, low};
  endfunction

  // {trap,priv,svc,we,bsel,mrd,mwr,wb,br,alu}
  function automatic logic [14:0] cw(logic t, logic p, logic s, logic w, logic b,
                                     logic r, logic m, logic [1:0] wbs, logic [1:0] brk, logic [3:0] a);
    return {t, p, s, w, b, r, m, wbs, brk, a};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic        sup;
    logic [14:0] ctl;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{mk(6'h20, 5'd3, 5'd1, 16'h1000), 1'b1, cw(0,0,0,1,0,0,0,2'd0,2'd0,4'h0), 4'd2},  // R2 add
    '{mk(6'h21, 5'd4, 5'd1, 16'h1000), 1'b1, cw(0,0,0,1,0,0,0,2'd0,2'd0,4'h1), 4'd2},  // R2 sub
    '{mk(6'h2E, 5'd4, 5'd2, 16'h1800), 1'b0, cw(0,0,0,1,0,0,0,2'd0,2'd0,4'hE), 4'd2},  // R2 sra
    '{mk(6'h30, 5'd5, 5'd1, 16'hFFFC), 1'b1, cw(0,0,0,1,1,0,0,2'd0,2'd0,4'h0), 4'd3},  // R3 addc
    '{mk(6'h3B, 5'd6, 5'd1, 16'h00FF), 1'b0, cw(0,0,0,1,1,0,0,2'd0,2'd0,4'hB), 4'd3},  // R3 xnorc
    '{mk(6'h18, 5'd7, 5'd2, 16'h0010), 1'b1, cw(0,0,0,1,1,1,0,2'd1,2'd0,4'h0), 4'd4},  // R4 load
    '{mk(6'h19, 5'd7, 5'd2, 16'h0010), 1'b1, cw(0,0,0,0,1,0,1,2'd0,2'd0,4'h0), 4'd5},  // R5 store
    '{mk(6'h1B, 5'd28, 5'd3, 16'h0000), 1'b0, cw(0,0,0,1,0,0,0,2'd2,2'd3,4'h0), 4'd6}, // R6 jump
    '{mk(6'h1C, 5'd31, 5'd3, 16'hFFF0), 1'b1, cw(0,0,0,0,1,0,0,2'd2,2'd1,4'h0), 4'd7}, // R7 beq, link dropped
    '{mk(6'h1D, 5'd28, 5'd3, 16'h0004), 1'b1, cw(0,0,0,1,1,0,0,2'd2,2'd2,4'h0), 4'd6}, // R6 bne
    '{mk(6'h20, 5'd31, 5'd1, 16'h1000), 1'b1, cw(0,0,0,0,0,0,0,2'd0,2'd0,4'h0), 4'd7}, // R7 add to 31
    '{mk(6'h27, 5'd3, 5'd1, 16'h1000), 1'b1, cw(1,0,0,0,0,0,0,2'd0,2'd0,4'h0), 4'd8},  // R8 gap
    '{mk(6'h1F, 5'd3, 5'd1, 16'h0004), 1'b1, cw(1,0,0,0,0,0,0,2'd0,2'd0,4'h0), 4'd8},  // R8
    '{mk(6'h05, 5'd3, 5'd1, 16'h0004), 1'b1, cw(1,0,0,0,0,0,0,2'd0,2'd0,4'h0), 4'd8},  // R8
    '{mk(6'h23, 5'd3, 5'd1, 16'h1000), 1'b1, cw(1,0,0,0,0,0,0,2'd0,2'd0,4'h0), 4'd9},  // R9 div
    '{mk(6'h33, 5'd3, 5'd1, 16'h0007), 1'b1, cw(1,0,0,0,0,0,0,2'd0,2'd0,4'h0), 4'd9},  // R9 divc
    '{mk(6'h00, 5'd0, 5'd0, 16'h0003), 1'b1, cw(0,1,0,0,0,0,0,2'd0,2'd0,4'h0), 4'd10}, // R10
    '{mk(6'h00, 5'd0, 5'd0, 16'h0003), 1'b0, cw(1,0,0,0,0,0,0,2'd0,2'd0,4'h0), 4'd11}, // R11 user
    '{mk(6'h00, 5'd0, 5'd0, 16'h0009), 1'b1, cw(1,0,0,0,0,0,0,2'd0,2'd0,4'h0), 4'd11}, // R11 fn 9
    '{mk(6'h01, 5'd0, 5'd0, 16'h0002), 1'b1, cw(1,0,1,0,0,0,0,2'd0,2'd0,4'h0), 4'd12}  // R12 svc
  };

  function automatic logic [14:0] got_ctl();
    return {trap, priv, svc, we, bsel, mrd, mwr, wb, br, alu_op};
  endfunction

  task automatic apply(logic [31:0] i, logic s);
    @(negedge clk);
    instr = i;
    sup = s;
    #5;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    instr = '0;
    sup = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R8 out of reset: all-zero word in user mode is a rejected privileged op
    apply(32'h0, 1'b0);
    chk("R8 reset ctl", 32'(got_ctl()), 32'(cw(1,0,0,0,0,0,0,2'd0,2'd0,4'h0)));

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].ins, VECS[k].sup);
      total++;
      if (got_ctl() !== VECS[k].ctl) begin
        bad++;
        $display("FAIL R%0d vec %0d act=%h exp=%h", VECS[k].req, k, got_ctl(), VECS[k].ctl);
      end
    end

    // R1 field positions and sign extension
    apply(mk(6'h30, 5'h15, 5'h0A, 16'h8801), 1'b1);
    chk("R1 opcode", 32'(opcode), 32'h30);
    chk("R1 rc", 32'(rc), 32'h15);
    chk("R1 ra", 32'(ra), 32'h0A);
    chk("R1 rb", 32'(rb), 32'h11);
    chk("R1 lit neg", lit, 32'hFFFF8801);
    apply(mk(6'h30, 5'h01, 5'h02, 16'h7FFF), 1'b1);
    chk("R1 lit pos", lit, 32'h00007FFF);

    // R2 read port B follows source B; R5 store steers destination onto it
    apply(mk(6'h2A, 5'd9, 5'd1, {5'd17, 11'd0}), 1'b1);
    chk("R2 rd_b", 32'(rd_b), 32'd17);
    chk("R12 func idle", 32'(func), 32'h0);
    apply(mk(6'h19, 5'd31, 5'd2, {5'd17, 11'h008}), 1'b1);
    chk("R5 rd_b", 32'(rd_b), 32'd31);
    chk("R5 mem_wr", 32'(mwr), 32'd1);

    // R10 function code passed through, top legal code 8
    apply(mk(6'h00, 5'd0, 5'd0, 16'h0008), 1'b1);
    chk("R10 priv fn8", 32'(priv), 32'd1);
    chk("R10 func", 32'(func), 32'h8);

    // R12 service call in user mode carries its code
    apply(mk(6'h01, 5'd4, 5'd0, 16'h00A5), 1'b0);
    chk("R12 svc", 32'({svc, trap, we}), 32'b110);
    chk("R12 func", 32'(func), 32'hA5);

    // R8 trap with live destination and register gap 0x3F
    apply(mk(6'h3F, 5'd12, 5'd3, 16'h1234), 1'b1);
    chk("R8 gap 3F", 32'(got_ctl()), 32'(cw(1,0,0,0,0,0,0,2'd0,2'd0,4'h0)));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule